// File: doc/BRIEF.md
# Dual-Source Bus Ready Synchronizer

This block combines two bus-ready requests into the one READY line that a processor samples to stretch a bus cycle with wait states. Each request has its own active-low address-enable input. A request counts only while its enable is low. The qualified result is never passed straight to the processor. It is captured in registers that advance only at processor-clock boundaries.

The block runs on the fast oscillator clock. An internal divide-by-DIV counter, three by default, marks each processor-clock boundary with a one-cycle phase enable. A run-time mode input selects the capture depth. One stage suits requests that already move in step with the processor clock. Two stages give extra settling time for requests that arrive asynchronously. In both modes READY stays low after reset until a qualified request has passed through the selected number of stages.

Top module: `rdy_sync_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `ready_o` is 0.
- R2: The qualified request is `(req_a & ~aen_a_n) | (req_b & ~aen_b_n)`. Each address enable is active low, and either source alone can raise READY.
- R3: A request whose address enable is high (1) has no effect on `ready_o`.
- R4: The processor-clock phase enable goes high for one fast clock out of every DIV (3 by default). The first one is on the DIV-th rising edge after reset is released, and every DIV-th edge after that.
- R5: `ready_o` changes only on the fast clock edge that follows a phase enable, never between processor-clock boundaries.
- R6: With `one_stage` = 1 at a boundary, `ready_o` after that boundary equals the qualified request sampled at that boundary. This is a latency of one processor clock, or 3 fast cycles at the default DIV.
- R7: With `one_stage` = 0 at a boundary, `ready_o` after that boundary equals the qualified request sampled at the previous boundary. This is a latency of two processor clocks, or 6 fast cycles at the default DIV.
- R8: `one_stage` is sampled only at boundaries. Changing it between boundaries does not change `ready_o` until the next boundary.
- R9: A request pulse that is gone before the next boundary edge is never seen at `ready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_a | input | 1 | Ready request, source A |
| aen_a_n | input | 1 | Active-low address enable that qualifies source A |
| req_b | input | 1 | Ready request, source B |
| aen_b_n | input | 1 | Active-low address enable that qualifies source B |
| one_stage | input | 1 | 1 selects one capture stage, 0 selects two |
| ready_o | output | 1 | Synchronized ready to the processor |

## Verification
A wrong phase count shows up at the ports at the first boundary after reset. READY then moves one or more fast cycles early or late, and the per-cycle compare catches it within DIV cycles. A first stage that holds a stale value, or a mode select that is read at the wrong time, shows up as a READY level that is wrong for a whole processor clock. This happens within two boundaries of the request changing. Bad qualification logic shows up as READY following a source whose enable is high, on the next boundary.

// File: rtl/rdy_pkg.sv
package rdy_pkg;
  typedef enum logic {
    SYNC_TWO = 1'b0,
    SYNC_ONE = 1'b1
  } sync_mode_e;

  function automatic logic qualify(input logic req, input logic en_n);
    return req & ~en_n;
  endfunction

  function automatic logic pick_next(input sync_mode_e m, input logic fresh,
                                     input logic held);
    return (m == SYNC_ONE) ? fresh : held;
  endfunction
endpackage

// File: rtl/rdy_phase_div.sv
module rdy_phase_div #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == LAST);
  assign tick = wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R4: a phase enable is never followed by another on the next cycle
  p_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R4: the count stays inside its range
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/rdy_qualify.sv
module rdy_qualify (
  input  logic clk,
  input  logic rst_n,
  input  logic req_a,
  input  logic aen_a_n,
  input  logic req_b,
  input  logic aen_b_n,
  output logic qual
);
  import rdy_pkg::*;

  logic hit_a, hit_b;
  assign hit_a = qualify(req_a, aen_a_n);
  assign hit_b = qualify(req_b, aen_b_n);
  assign qual  = hit_a | hit_b;

  // R3: with both enables high, nothing is qualified
  p_both_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (aen_a_n && aen_b_n) |-> !qual);
  // R2: an enabled, requesting source always qualifies
  p_src_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_a && !aen_a_n) |-> qual);
endmodule

// File: rtl/rdy_sync_stages.sv
module rdy_sync_stages (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic one_stage,
  input  logic d,
  output logic st1,
  output logic q
);
  import rdy_pkg::*;

  sync_mode_e mode;
  logic       nxt;

  assign mode = sync_mode_e'(one_stage);
  assign nxt  = pick_next(mode, d, st1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1 <= 1'b0;
      q   <= 1'b0;
    end else if (tick) begin
      st1 <= d;
      q   <= nxt;
    end
  end

  // R5: the output moves only at a boundary
  p_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(q));
  // R6: single stage follows the sample taken at this boundary
  p_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && one_stage) |=> (q == $past(d)));
  // R7: two stages follow the first stage's earlier sample
  p_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !one_stage) |=> (q == $past(st1)));
endmodule

// File: rtl/rdy_sync_top.sv
module rdy_sync_top #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_a,
  input  logic aen_a_n,
  input  logic req_b,
  input  logic aen_b_n,
  input  logic one_stage,
  output logic ready_o
);
  logic tick;
  logic qual;
  logic st1;

  rdy_phase_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  rdy_qualify u_qual (
    .clk(clk), .rst_n(rst_n),
    .req_a(req_a), .aen_a_n(aen_a_n),
    .req_b(req_b), .aen_b_n(aen_b_n),
    .qual(qual)
  );

  rdy_sync_stages u_sync (
    .clk(clk), .rst_n(rst_n), .tick(tick), .one_stage(one_stage),
    .d(qual), .st1(st1), .q(ready_o)
  );

  // R1: the first cycle after reset never shows READY
  p_reset_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !ready_o);
  // R9: READY rises only after a boundary
  p_rise_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> !tick);
endmodule

// File: tb/sim_rdy_sync_top.sv
module sim_rdy_sync_top;
  localparam int DIV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_a = 1'b0, aen_a_n = 1'b1, req_b = 1'b0, aen_b_n = 1'b1;
  logic one_stage = 1'b1;
  logic ready_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rdy_sync_top #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .req_a(req_a), .aen_a_n(aen_a_n),
    .req_b(req_b), .aen_b_n(aen_b_n), .one_stage(one_stage),
    .ready_o(ready_o)
  );

  // reference model: edge counter and a history of boundary samples
  int  edges;
  bit  hist[$];
  bit  exp_rdy;

  function automatic bit want(input logic a, input logic ea, input logic b,
                              input logic eb);
    bit r;
    r = 0;
    if (a === 1'b1 && ea === 1'b0) r = 1;
    if (b === 1'b1 && eb === 1'b0) r = 1;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges = 0;
      hist.delete();
      exp_rdy = 0;
    end else begin
      edges = edges + 1;
      if (edges % DIV == 0) begin
        bit now;
        now = want(req_a, aen_a_n, req_b, aen_b_n);
        if (one_stage) exp_rdy = now;
        else exp_rdy = (hist.size() > 0) ? hist[hist.size()-1] : 1'b0;
        hist.push_back(now);
        if (hist.size() > 4) void'(hist.pop_front());
      end
    end
  end

  task automatic check(input logic act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // per-cycle compare against the model, away from the active edge
  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on) check(ready_o, exp_rdy, "R5 R6 R7 R8 R9 model");
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    cmp_on = 0;
    @(negedge clk);
    rst_n = 0;
    cyc(2);
    check(ready_o, 1'b0, "R1 in reset");
    rst_n = 1;
    @(negedge clk);
    check(ready_o, 1'b0, "R1 after release");
    cmp_on = 1;
  endtask

  // wait for the negedge just after a boundary edge
  task automatic align();
    @(negedge clk);
    while (edges % DIV != 0) @(negedge clk);
  endtask

  task automatic latency(input bit mode, input int exp_n, input string tag);
    int n;
    req_a = 0; req_b = 0; aen_a_n = 0; aen_b_n = 1; one_stage = mode;
    cyc(4 * DIV);
    align();
    req_a = 1;
    n = 0;
    while (ready_o !== 1'b1 && n < 20) begin
      @(negedge clk);
      n++;
    end
    checks++;
    if (n != exp_n) begin
      fails++;
      $display("FAIL %s latency actual=%0d expected=%0d", tag, n, exp_n);
    end
    req_a = 0;
    cyc(3 * DIV);
  endtask

  initial begin : wdog
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    cyc(3);
    rst_n = 1;
    do_reset();

    // R3: requests with enables high are ignored
    req_a = 1; req_b = 1; aen_a_n = 1; aen_b_n = 1; one_stage = 1;
    cyc(5 * DIV);
    check(ready_o, 1'b0, "R3 disabled sources");

    // R2: source B alone
    aen_b_n = 0;
    cyc(2 * DIV + 1);
    check(ready_o, 1'b1, "R2 source B alone");
    aen_b_n = 1; req_b = 0;
    cyc(2 * DIV + 1);
    check(ready_o, 1'b0, "R3 B disabled again");

    // R6/R7 latency, in fast cycles
    latency(1'b1, DIV, "R6 one stage");
    latency(1'b0, 2 * DIV, "R7 two stage");

    // R9: one-cycle pulse between boundaries
    one_stage = 1; aen_a_n = 0; req_a = 0;
    align();
    req_a = 1; @(negedge clk); req_a = 0;
    cyc(3 * DIV);
    check(ready_o, 1'b0, "R9 short pulse lost");

    // mixed patterns, including mode flips between boundaries (R8)
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_a = lfsr[0]; req_b = lfsr[3];
      aen_a_n = lfsr[5] & lfsr[6];
      aen_b_n = ~(lfsr[7] | lfsr[8]);
      if (lfsr[9] && lfsr[11]) one_stage = ~one_stage;
      cyc(1 + int'(lfsr[2]));
    end

    // reset during activity
    req_a = 1; aen_a_n = 0;
    cyc(4 * DIV);
    do_reset();
    cyc(8 * DIV);

    done = 1;
    cmp_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule